// File: doc/BRIEF.md
# Over-Temperature Alarm with Consecutive-Fault Qualifier

This block watches a stream of signed temperature samples and drives the pull-down enable of an open-drain alarm pin. Each sample arrives as a left-justified 16-bit word together with a one-cycle valid strobe. The block compares it against a trip limit and a hysteresis limit, which come from registers held elsewhere. A sample only counts toward a trip after a programmable number of consecutive out-of-limit samples.

There are two alarm modes. In thermostat mode the alarm rises above the trip limit and falls back below the hysteresis limit. In event mode every qualified crossing latches the alarm until the bus interface reports a register read. The direction watched alternates between the upper and the lower crossing after each event.

A polarity bit picks the active pin level, and a shutdown bit freezes sample processing. The configuration arrives as five bits. From the least significant bit up they are:
- bit 0: shutdown.
- bit 1: mode, 0 for thermostat and 1 for event.
- bit 2: polarity.
- bits 4:3: fault-queue depth.

Top module: `therm_alarm`

## Requirements
- R1: Sample, trip and hysteresis values are 9-bit two's complement numbers taken from bits 15:7 of their 16-bit words (LSB = 0.5 °C). Bits 6:0 have no effect on the output.
- R2: In thermostat mode (cfgBits[1]=0), an inactive alarm becomes active once the qualified number of consecutive valid samples are strictly greater than the trip limit. The output changes right after the clock edge that takes the last such sample.
- R3: In thermostat mode, an active alarm becomes inactive only once the qualified number of consecutive samples are strictly less than the hysteresis limit. regRead has no effect in this mode.
- R4: cfgBits[4:3] sets the number of consecutive qualifying samples: 00→1, 01→2, 10→4, 11→6. A valid sample that does not qualify restarts the count from zero. Cycles without sampleValid do not break the run.
- R5: In event mode (cfgBits[1]=1), a qualified crossing sets the alarm. The alarm then stays set, ignoring samples, until a cycle with regRead high clears it.
- R6: In event mode the first crossing watched after reset is the upper one (sample > trip). After each event, the watched crossing switches between upper and lower (sample < hysteresis).
- R7: pullDownEn equals alarm XOR cfgBits[2]. With 0, the pin is pulled low while the alarm is active. With 1, the pin is pulled low while it is inactive.
- R8: While cfgBits[0]=1, valid samples are ignored and the fault count is cleared. In event mode, shutdown also clears the alarm.
- R9: After reset the alarm is inactive, the fault count is zero and the upper crossing is armed. With cfgBits=0 the pin is released (pullDownEn=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One-cycle strobe marking a new temperature sample |
| sampleWord | input | 16 | Sample, value in bits 15:7 |
| tripWord | input | 16 | Trip limit, value in bits 15:7 |
| hystWord | input | 16 | Hysteresis limit, value in bits 15:7 |
| cfgBits | input | 5 | Shutdown, mode, polarity and fault-queue depth |
| regRead | input | 1 | Pulse from the bus interface: a register was read |
| pullDownEn | output | 1 | Drives the open-drain alarm pin low when high |

## Verification
The internal state consists of three parts: the alarm bit, the armed direction of event mode and the consecutive-fault count. A wrong alarm bit shows on pullDownEn right after the next clock edge. A wrong armed direction stays hidden until the next read clears the alarm, and then shows as a trip on the wrong crossing. A wrong count is invisible until a run of qualifying samples reaches the depth, and then shows as a trip one or more samples early or late. For that reason the sweeps ramp the sample across the full 9-bit range in both directions, under every mode, polarity and depth. They compare the pin on every cycle, which also puts the count boundaries at each depth setting.

// File: rtl/therm_pkg.sv
package therm_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic evalEn;     // take the current sample into the fault count
    logic watchHigh;  // 1: upper crossing qualifies, 0: lower crossing
    logic clearCount; // restart the fault count
  } ctlStrobes_t;
endpackage

// File: rtl/therm_datapath.sv
module therm_datapath
  import therm_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int VAL_W  = 9,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] sampleWord,
  input  logic [WORD_W-1:0] tripWord,
  input  logic [WORD_W-1:0] hystWord,
  input  logic [1:0]        queueSel,
  input  ctlStrobes_t       ctl,
  output logic              fireEvt
);
  localparam int LO = WORD_W - VAL_W;

  logic signed [VAL_W-1:0] tempVal, tripVal, hystVal;
  logic hot, cold, hit;
  logic [CNT_W-1:0] faultCnt, need, cntNext;

  assign tempVal = sampleWord[WORD_W-1:LO];
  assign tripVal = tripWord[WORD_W-1:LO];
  assign hystVal = hystWord[WORD_W-1:LO];

  assign hot  = tempVal > tripVal;
  assign cold = tempVal < hystVal;
  assign hit  = ctl.watchHigh ? hot : cold;

  always_comb begin
    unique case (queueSel)
      2'b00:   need = CNT_W'(1);
      2'b01:   need = CNT_W'(2);
      2'b10:   need = CNT_W'(4);
      default: need = CNT_W'(6);
    endcase
  end

  assign cntNext = faultCnt + CNT_W'(1);
  assign fireEvt = ctl.evalEn && hit && (cntNext >= need);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clearCount) faultCnt <= '0;
    else if (ctl.evalEn) begin
      if (!hit || fireEvt) faultCnt <= '0;
      else                 faultCnt <= cntNext;
    end
  end

  // the run never reaches the deepest setting without firing
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    faultCnt <= CNT_W'(5));
  // without an evaluated sample the run length is frozen
  assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.evalEn && !ctl.clearCount) |=> $stable(faultCnt));
  // shutdown empties the run
  assert_count_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearCount |=> (faultCnt == '0));
endmodule

// File: rtl/therm_control.sv
module therm_control
  import therm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic        intMode,
  input  logic        shutdown,
  input  logic        regRead,
  input  logic        fireEvt,
  output ctlStrobes_t ctl,
  output logic        alarm
);
  logic armHigh;

  always_comb begin
    ctl.evalEn     = sampleValid && !shutdown && !(intMode && alarm);
    ctl.watchHigh  = intMode ? armHigh : !alarm;
    ctl.clearCount = shutdown;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alarm   <= 1'b0;
      armHigh <= 1'b1;
    end else if (intMode) begin
      if (shutdown) alarm <= 1'b0;
      else if (fireEvt) begin
        alarm   <= 1'b1;
        armHigh <= !armHigh;
      end else if (regRead) alarm <= 1'b0;
    end else if (fireEvt) begin
      alarm <= !alarm;
    end
  end

  assert_therm_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!intMode && !fireEvt) |=> $stable(alarm));
  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (intMode && alarm && !regRead && !shutdown) |=> alarm);
  assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (intMode && alarm && regRead) |=> !alarm);
  assert_alternate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (intMode && $rose(alarm)) |-> (armHigh != $past(armHigh)));
  assert_shut_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (intMode && shutdown) |=> !alarm);
endmodule

// File: rtl/therm_alarm.sv
module therm_alarm
  import therm_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int VAL_W  = 9,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [WORD_W-1:0] sampleWord,
  input  logic [WORD_W-1:0] tripWord,
  input  logic [WORD_W-1:0] hystWord,
  input  logic [4:0]        cfgBits,
  input  logic              regRead,
  output logic              pullDownEn
);
  ctlStrobes_t ctl;
  logic fireEvt, alarm;

  therm_datapath #(.WORD_W(WORD_W), .VAL_W(VAL_W), .CNT_W(CNT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .sampleWord(sampleWord), .tripWord(tripWord),
    .hystWord(hystWord), .queueSel(cfgBits[4:3]), .ctl(ctl), .fireEvt(fireEvt)
  );

  therm_control u_control (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .intMode(cfgBits[1]),
    .shutdown(cfgBits[0]), .regRead(regRead), .fireEvt(fireEvt),
    .ctl(ctl), .alarm(alarm)
  );

  assign pullDownEn = alarm ^ cfgBits[2];

  assert_reset_idle_R9: assert property (@(posedge clk)
    !rstN |=> !alarm);
endmodule

// File: tb/therm_alarm_bench.sv
module therm_alarm_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [15:0] sampleWord = '0, tripWord = 16'h5000, hystWord = 16'h4B00;
  logic [4:0] cfgBits = '0;
  logic regRead = 1'b0;
  logic pullDownEn;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference state, built from the requirements
  bit mAlarm, mArm;
  int mCnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  therm_alarm u_therm_alarm (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleWord(sampleWord),
    .tripWord(tripWord), .hystWord(hystWord), .cfgBits(cfgBits),
    .regRead(regRead), .pullDownEn(pullDownEn)
  );

  function automatic logic [15:0] mkWord(int v);
    logic [8:0] v9 = 9'(v);
    return {v9, 7'($urandom)}; // R1: low bits are noise
  endfunction

  function automatic int val9(logic [15:0] w);
    return int'($signed(w[15:7]));
  endfunction

  function automatic int depth(logic [1:0] q);
    case (q) 2'b00: return 1; 2'b01: return 2; 2'b10: return 4; default: return 6; endcase
  endfunction

  task automatic check(bit got, bit exp, string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: pullDownEn=%0b expected %0b (cfg=%b t=%0d trip=%0d hyst=%0d)",
               tag, got, exp, cfgBits, val9(sampleWord), val9(tripWord), val9(hystWord));
    end
  endtask

  task automatic modelReset();
    mAlarm = 1'b0; mArm = 1'b1; mCnt = 0;
  endtask

  // apply inputs for one cycle, advance the reference, check after the edge
  task automatic step(bit sv, int t, bit rd);
    bit hit, fire;
    int need;
    sampleValid = sv; sampleWord = mkWord(t); regRead = rd;
    need = depth(cfgBits[4:3]);
    if (cfgBits[0]) begin // R8
      mCnt = 0;
      if (cfgBits[1]) mAlarm = 1'b0;
    end else if (cfgBits[1]) begin
      fire = 1'b0;
      if (sv && !mAlarm) begin
        hit = mArm ? (t > val9(tripWord)) : (t < val9(hystWord));
        if (hit && mCnt + 1 >= need) begin fire = 1'b1; mCnt = 0; end
        else mCnt = hit ? mCnt + 1 : 0;
      end
      if (fire) begin mAlarm = 1'b1; mArm = !mArm; end // R5, R6
      else if (rd) mAlarm = 1'b0;
    end else if (sv) begin
      hit = mAlarm ? (t < val9(hystWord)) : (t > val9(tripWord)); // R2, R3
      if (hit && mCnt + 1 >= need) begin mAlarm = !mAlarm; mCnt = 0; end
      else mCnt = hit ? mCnt + 1 : 0;
    end
    @(posedge clk);
    @(negedge clk);
    check(pullDownEn, mAlarm ^ cfgBits[2],
          cfgBits[0] ? "R8" : (cfgBits[1] ? "R5 R6 R4 R7 R1" : "R2 R3 R4 R7 R1"));
  endtask

  task automatic doReset();
    rstN = 1'b0; sampleValid = 1'b0; regRead = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    check(pullDownEn, 1'b0, "R9"); // released after reset, cfg 0

    // ramp sweeps across the full 9-bit range, every cfg except shutdown
    for (int c = 0; c < 16; c++) begin
      cfgBits = {c[3:2], c[1], c[0], 1'b0};
      tripWord = mkWord(c < 8 ? 160 : -20);
      hystWord = mkWord(c < 8 ? 150 : -40);
      doReset();
      for (int t = -256; t < 256; t++) step(1'b1, t, (t % 37) == 0);
      for (int t = 255; t >= -256; t--) step((t % 5) != 0, t, (t % 41) == 0);
    end

    // randomized walks with reads, gaps and shutdown windows
    for (int c = 0; c < 32; c++) begin
      int t;
      cfgBits = {c[4:3], c[2], c[1], 1'b0};
      tripWord = mkWord(int'($urandom_range(40)) - 10);
      hystWord = mkWord(val9(tripWord) - int'($urandom_range(8)));
      doReset();
      t = 0;
      for (int i = 0; i < 400; i++) begin
        if (i == 150) cfgBits[0] = 1'b1; // R8 window
        if (i == 180) cfgBits[0] = 1'b0;
        t = t + int'($urandom_range(8)) - 4;
        if (t > 60) t = 60;
        if (t < -60) t = -60;
        step($urandom_range(3) != 0, t, $urandom_range(9) == 0);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule